// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces a one-bit keystream from three maximal-length linear feedback shift registers. One register acts as the clock controller. The other two hold the data. On every enabled step the controller's current top bit picks which data register moves: data register A when the bit is 1, data register B when it is 0. The controller itself moves on every enabled step. The keystream bit is the XOR of the top bits of the two data registers.

The register lengths are 29 (control), 31 (data A) and 33 (data B). Each uses a fixed primitive trinomial, so every register has full period. A synchronous load writes all three starting states in one cycle, and a load takes priority over a step requested in the same cycle. A seed of all zeros would lock a register, so it is replaced by the value 1.

The user loads the seeds, then raises `step` once per wanted bit. After each enabled step, `ks_valid` is high for one cycle and `ks_bit` holds the new keystream bit.

Top module: `asg_keystream_gen`

## Requirements
- R1: Each register of width W and tap T advances as `next = {q[W-2:0], q[W-1] ^ q[T-1]}`. The settings are control W=29, T=2; data A W=31, T=3; data B W=33, T=13. The output bit of each register is its bit W-1.
- R2: When `load` is high at a rising edge, the control, A and B registers take `seed_ctrl`, `seed_a` and `seed_b` at that edge.
- R3: On an enabled step, exactly one data register advances. A advances when the control register's bit 28 is 1 before the edge, and B advances when that bit is 0.
- R4: The control register advances on every enabled step. It advances at the same edge at which its old bit 28 chooses the data register.
- R5: `ks_bit` always equals A bit 30 XOR B bit 32 of the present states. `ks_valid` is high in the cycle after an edge where `step` was high and `load` was low.
- R6: When `load` and `step` are high together, the load is applied, no register steps, and `ks_valid` is low in the following cycle.
- R7: When `step` and `load` are both low, no register changes and `ks_valid` is low in the following cycle.
- R8: An all-zero seed for any register is stored as the value 1 in that register.
- R9: Synchronous active-high `rst` sets every register to the value 1 and clears `ks_valid`, so `ks_bit` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write all three seeds |
| seed_ctrl | input | 29 | Starting state of the control register |
| seed_a | input | 31 | Starting state of data register A |
| seed_b | input | 33 | Starting state of data register B |
| step | input | 1 | Produce one keystream bit |
| ks_bit | output | 1 | Keystream bit |
| ks_valid | output | 1 | New keystream bit present |

## Verification
Loading and stepping can be requested in the same cycle. The bench provokes this by raising `load` and `step` together on nonzero seeds. It then judges the outcome in two ways: `ks_valid` must be low in the next cycle, and `ks_bit` must equal the XOR of the loaded seeds' top bits. After that, the bench keeps stepping and compares every further bit against its own register model started from exactly those seeds, which would reveal any step that leaked through. Long runs from several seed sets compare the keystream bit-exactly against that model.

// File: rtl/asg_pkg.sv
package asg_pkg;

    localparam int CTRL_W   = 29;
    localparam int CTRL_TAP = 2;
    localparam int DA_W     = 31;
    localparam int DA_TAP   = 3;
    localparam int DB_W     = 33;
    localparam int DB_TAP   = 13;

    // Per-step advance enables for the three registers
    typedef struct packed {
        logic ctrl_en;
        logic a_en;
        logic b_en;
    } asg_en_t;

endpackage

// File: rtl/asg_lfsr.sv
module asg_lfsr #(
    parameter int W   = 31,
    parameter int TAP = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam logic [W-1:0] NONZERO = W'(1);

    logic [W-1:0] q;
    logic [W-1:0] shifted;
    logic [W-1:0] seed_safe;

    assign shifted   = {q[W-2:0], q[W-1] ^ q[TAP-1]};
    assign seed_safe = (seed == '0) ? NONZERO : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= NONZERO;
        end else if (load) begin
            q <= seed_safe;
        end else if (adv) begin
            q <= shifted;
        end
    end

    assign state = q;
endmodule

// File: rtl/asg_step_sel.sv
module asg_step_sel
    import asg_pkg::*;
(
    input  logic    step,
    input  logic    load,
    input  logic    ctrl_bit,
    output asg_en_t en
);
    logic go;

    assign go         = step & ~load;
    assign en.ctrl_en = go;
    assign en.a_en    = go & ctrl_bit;
    assign en.b_en    = go & ~ctrl_bit;
endmodule

// File: rtl/asg_keystream_gen.sv
module asg_keystream_gen
    import asg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CTRL_W-1:0] seed_ctrl,
    input  logic [DA_W-1:0]   seed_a,
    input  logic [DB_W-1:0]   seed_b,
    input  logic              step,
    output logic              ks_bit,
    output logic              ks_valid
);
    logic [CTRL_W-1:0] ctrl_state;
    logic [DA_W-1:0]   a_state;
    logic [DB_W-1:0]   b_state;
    asg_en_t           en;
    logic              valid_q;

    asg_step_sel u_sel (
        .step     (step),
        .load     (load),
        .ctrl_bit (ctrl_state[CTRL_W-1]),
        .en       (en)
    );

    asg_lfsr #(.W(CTRL_W), .TAP(CTRL_TAP)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .seed  (seed_ctrl),
        .adv   (en.ctrl_en),
        .state (ctrl_state)
    );

    asg_lfsr #(.W(DA_W), .TAP(DA_TAP)) u_data_a (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .seed  (seed_a),
        .adv   (en.a_en),
        .state (a_state)
    );

    asg_lfsr #(.W(DB_W), .TAP(DB_TAP)) u_data_b (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .seed  (seed_b),
        .adv   (en.b_en),
        .state (b_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= en.ctrl_en;
        end
    end

    assign ks_bit   = a_state[DA_W-1] ^ b_state[DB_W-1];
    assign ks_valid = valid_q;
endmodule

// File: rtl/asg_checker.sv
module asg_checker
    import asg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              step,
    input logic              ks_valid,
    input logic [DA_W-1:0]   seed_a,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [DA_W-1:0]   a_q,
    input logic [DB_W-1:0]   b_q
);
    AST_ONE_DATA_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ($stable(a_q) != $stable(b_q))); // R3

    AST_SELECT_A: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ctrl_q[CTRL_W-1]) |=> !$stable(a_q)); // R3

    AST_CTRL_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> !$stable(ctrl_q)); // R4

    AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> ks_valid); // R5

    AST_LOAD_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        load |=> !ks_valid); // R6

    AST_LOAD_SEED_A: assert property (@(posedge clk) disable iff (rst)
        (load && seed_a != '0) |=> (a_q == $past(seed_a))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> ($stable(ctrl_q) && $stable(a_q) && $stable(b_q) && !ks_valid)); // R7

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
        load |=> (ctrl_q != '0 && a_q != '0 && b_q != '0)); // R8
endmodule

bind asg_keystream_gen asg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .ks_valid (ks_valid),
    .seed_a   (seed_a),
    .ctrl_q   (ctrl_state),
    .a_q      (a_state),
    .b_q      (b_state)
);

// File: tb/tb_asg_keystream_gen.sv
module tb_asg_keystream_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [28:0] seed_ctrl;
    logic [30:0] seed_a;
    logic [32:0] seed_b;
    logic        step;
    logic        ks_bit;
    logic        ks_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [28:0] mc;
    logic [30:0] ma;
    logic [32:0] mb;

    always #5 clk = ~clk;

    asg_keystream_gen dut (
        .clk(clk), .rst(rst), .load(load), .seed_ctrl(seed_ctrl),
        .seed_a(seed_a), .seed_b(seed_b), .step(step),
        .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    // Seed table: {control, data A, data B}, walked by the main loop
    localparam int NSEED = 4;
    localparam int NSTEP = 2600;
    localparam logic [92:0] SEEDS [NSEED] = '{
        {29'h1ABCDEF1, 31'h12345678, 33'h0DEADBEEF},
        {29'h00000001, 31'h7FFFFFFF, 33'h000000001},
        {29'h1FFFFFFF, 31'h00000001, 33'h1FFFFFFFF},
        {29'h0F0F0F0F, 31'h55555555, 33'h0AAAAAAAA}
    };

    function automatic logic [28:0] nz_c(input logic [28:0] s); return (s == '0) ? 29'd1 : s; endfunction
    function automatic logic [30:0] nz_a(input logic [30:0] s); return (s == '0) ? 31'd1 : s; endfunction
    function automatic logic [32:0] nz_b(input logic [32:0] s); return (s == '0) ? 33'd1 : s; endfunction

    // Behavioural model of one enabled step (R1, R3, R4)
    task automatic model_step();
        if (mc[28]) ma = {ma[29:0], ma[30] ^ ma[2]};
        else        mb = {mb[31:0], mb[32] ^ mb[12]};
        mc = {mc[27:0], mc[28] ^ mc[1]};
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic do_load(input logic [28:0] c, input logic [30:0] a, input logic [32:0] b, input logic with_step);
        @(negedge clk);
        load = 1'b1; step = with_step;
        seed_ctrl = c; seed_a = a; seed_b = b;
        @(negedge clk);
        load = 1'b0; step = 1'b0;
        mc = nz_c(c); ma = nz_a(a); mb = nz_b(b);
    endtask

    // Run n enabled steps, checking every resulting bit against the model
    task automatic run_steps(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step = 1'b1;
            @(negedge clk);
            model_step();
            chk({req, " valid"}, ks_valid, 1'b1);
            chk({req, " bit"}, ks_bit, ma[30] ^ mb[32]);
        end
        step = 1'b0;
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; load = 1'b0; step = 1'b0;
        seed_ctrl = '0; seed_a = '0; seed_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state, every register holds 1
        chk("R9 valid", ks_valid, 1'b0);
        chk("R9 bit", ks_bit, 1'b0);
        mc = 29'd1; ma = 31'd1; mb = 33'd1;
        run_steps(100, "R9 R1");

        // Main table walk: long runs from several seeds (R1 R2 R3 R4 R5)
        for (int s = 0; s < NSEED; s++) begin
            do_load(SEEDS[s][92:64], SEEDS[s][63:33], SEEDS[s][32:0], 1'b0);
            chk("R2 bit after load", ks_bit, ma[30] ^ mb[32]);
            run_steps(NSTEP, "R1 R3 R4 R5");
        end

        // R6: load and step together, load wins and no step follows
        do_load(29'h10000000, 31'h40000000, 33'h000000000, 1'b1);
        chk("R6 valid", ks_valid, 1'b0);
        chk("R6 bit", ks_bit, 1'b1);
        // R3: control top bit 1 selects A first: A=0x40000000 -> new top 0, B unchanged
        run_steps(1, "R3");
        run_steps(300, "R6 R3");

        // R7: idle cycles change nothing
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7 valid", ks_valid, 1'b0);
            chk("R7 bit", ks_bit, ma[30] ^ mb[32]);
        end
        run_steps(200, "R7 continue");

        // R8: all-zero seeds become 1
        do_load('0, '0, '0, 1'b0);
        chk("R8 bit", ks_bit, 1'b0);
        run_steps(300, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule